// File: doc/BRIEF.md
# Two-Button Ordered-Gesture Counter

This block counts deliberate user gestures made with two push-buttons, a left one and a right one. A small state machine follows the button levels. It advances a 3-bit up-counter only after one complete ordered gesture: the left button goes down and comes back up, and then the right button goes down and comes back up. Contact bounce shows up as repeated transitions on one button. Repeated transitions on one button can never finish the two-button order, so bounce does not add counts and no timing filter is needed.

The button inputs must already be synchronous to the clock. The current machine state is driven out as a 2-bit code, so the gesture can be observed next to the count. The reset input clears every register at once. The internal release of reset is retimed to the clock.

Top module: `seq_gate_counter`

## Requirements
- R1: While `rst_n_i` is low, `state_o` reads 0 and `count_o` reads 0. Both clear as soon as `rst_n_i` falls, without waiting for a clock edge. After `rst_n_i` rises, the block starts working within two rising edges.
- R2: `count_o` rises by exactly one on the rising edge at which the machine is in the right-held state and `right_i` is sampled low. No other edge changes `count_o`.
- R3: `state_o` encodes idle as 0, left-held as 1, left-complete as 2 and right-held as 3. On each rising edge the next state is chosen as follows. Idle goes to 1 when only left is high. State 1 goes to 2 when left is low. State 2 goes to 3 when only right is high, and to 1 when only left is high. State 3 goes to 0 when right is low. In every other case the state holds.
- R4: In idle, pressing and releasing the right button alone leaves `state_o` at 0 and leaves `count_o` unchanged.
- R5: In the left-complete state, another left press and release goes through state 1 and back to state 2 without counting. The machine then still accepts a right press and release as the end of the gesture.
- R6: Pressing and releasing right again after a completed gesture adds no count.
- R7: When `left_i` and `right_i` are both high on a rising edge, the next state is 0 from any state and `count_o` does not change.
- R8: The count wraps from 7 to 0 on the eighth completed gesture. No overflow indication exists.
- R9: The press/release series left, left, right, right, left, right, each separated by multi-cycle idle pauses and starting from a count of 0, ends with `count_o` equal to 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all registers update on its rising edge |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| left_i | input | 1 | Left button level, high while pressed, already synchronous |
| right_i | input | 1 | Right button level, high while pressed, already synchronous |
| count_o | output | 3 | Completed-gesture count, wraps modulo 8 |
| state_o | output | 2 | Current gesture state code (0 idle, 1 left-held, 2 left-complete, 3 right-held) |

## Verification
The hardest cases to reach are the less common arcs out of the left-complete and right-held states. These are a second left press while waiting for right, and a press of both buttons in the middle of a gesture. A plain button script reaches them only by chance. The stimulus therefore first steers the machine into each of the four states with a fixed prefix. It then applies each of the four input combinations there and compares against an arithmetic model kept in the bench. A long pseudo-random run of held levels then visits the remaining interleavings. Separate scripted runs cover the eight-gesture wrap and an asynchronous reset applied between clock edges.

// File: rtl/seq_gate_pkg.sv
package seq_gate_pkg;

  localparam int unsigned STATE_W = 2;

  typedef enum logic [STATE_W-1:0] {
    ST_IDLE       = 2'd0,
    ST_LEFT_HELD  = 2'd1,
    ST_LEFT_SEEN  = 2'd2,
    ST_RIGHT_HELD = 2'd3
  } gest_state_e;

endpackage

// File: rtl/seq_gate_rst_sync.sv
module seq_gate_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_n_i,
  output logic rst_n_o
);

  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] chain_q;

  // Assertion reaches every stage at once; release ripples in from stage 0.
  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_o = chain_q[LAST];

endmodule

// File: rtl/seq_gate_fsm.sv
module seq_gate_fsm
  import seq_gate_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_n_i,
  input  logic        left_i,
  input  logic        right_i,
  output gest_state_e state_o,
  output logic        step_o
);

  gest_state_e state_q;
  gest_state_e state_d;
  logic        both_w;

  assign both_w = left_i & right_i;

  // Next-state decode. A press of both buttons always abandons the gesture.
  always_comb begin
    state_d = state_q;
    step_o  = 1'b0;
    if (both_w) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (left_i) state_d = ST_LEFT_HELD;
        end
        ST_LEFT_HELD: begin
          if (!left_i) state_d = ST_LEFT_SEEN;
        end
        ST_LEFT_SEEN: begin
          if (right_i)     state_d = ST_RIGHT_HELD;
          else if (left_i) state_d = ST_LEFT_HELD;
        end
        ST_RIGHT_HELD: begin
          if (!right_i) begin
            state_d = ST_IDLE;
            step_o  = 1'b1;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  assign state_o = state_q;

endmodule

// File: rtl/seq_gate_wrap_cnt.sv
module seq_gate_wrap_cnt #(
  parameter int unsigned WIDTH = 3
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic             en_i,
  output logic [WIDTH-1:0] value_o
);

  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

  logic [WIDTH-1:0] value_q;
  logic [WIDTH-1:0] value_d;

  always_comb begin
    value_d = value_q;
    if (en_i) value_d = value_q + ONE;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      value_q <= '0;
    end else if (en_i) begin
      value_q <= value_d;
    end
  end

  assign value_o = value_q;

endmodule

// File: rtl/seq_gate_counter.sv
module seq_gate_counter
  import seq_gate_pkg::*;
#(
  parameter int unsigned CNT_W       = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic             left_i,
  input  logic             right_i,
  output logic [CNT_W-1:0] count_o,
  output logic [1:0]       state_o
);

  logic        rst_sync_n;
  logic        step_w;
  gest_state_e fsm_state;

  seq_gate_rst_sync #(
    .STAGES (SYNC_STAGES)
  ) u_rst (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_i),
    .rst_n_o (rst_sync_n)
  );

  seq_gate_fsm u_fsm (
    .clk_i   (clk_i),
    .rst_n_i (rst_sync_n),
    .left_i  (left_i),
    .right_i (right_i),
    .state_o (fsm_state),
    .step_o  (step_w)
  );

  seq_gate_wrap_cnt #(
    .WIDTH (CNT_W)
  ) u_cnt (
    .clk_i   (clk_i),
    .rst_n_i (rst_sync_n),
    .en_i    (step_w),
    .value_o (count_o)
  );

  assign state_o = fsm_state;

endmodule

// File: rtl/seq_gate_counter_chk.sv
module seq_gate_counter_chk #(
  parameter int unsigned CNT_W = 3
) (
  input logic             clk_i,
  input logic             rst_n_i,
  input logic             rst_sync_n,
  input logic             left_i,
  input logic             right_i,
  input logic [CNT_W-1:0] count_o,
  input logic [1:0]       state_o
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  // R1: outputs read zero while the reset pin is held low
  always @(negedge clk_i) begin
    if (!rst_n_i) begin
      assert_reset_clear_R1: assert (state_o == 2'd0 && count_o == '0)
        else $error("reset did not clear outputs");
    end
  end

  // R2: a count change is only possible out of the right-held state
  assert_count_src_R2: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (count_o != $past(count_o)) |-> ($past(state_o) == 2'd3));

  // R2: releasing right in the right-held state produces one increment
  assert_count_step_R2: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (state_o == 2'd3 && !right_i) |=> (count_o == $past(count_o) + ONE));

  // R8: every change is a single modulo step
  assert_no_overflow_R8: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (count_o != $past(count_o)) |-> (count_o == $past(count_o) + ONE));

  // R4: idle ignores the right button
  assert_idle_right_ignored_R4: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (state_o == 2'd0 && !left_i) |=> (state_o == 2'd0));

  // R7: both buttons together abandon the gesture without counting
  assert_both_abort_R7: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (left_i && right_i) |=> (state_o == 2'd0 && $stable(count_o)));

  // R5: a left press while waiting for right goes back to left-held
  assert_left_again_R5: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (state_o == 2'd2 && left_i && !right_i) |=> (state_o == 2'd1));

endmodule

bind seq_gate_counter seq_gate_counter_chk #(
  .CNT_W (CNT_W)
) chk_i (
  .clk_i      (clk_i),
  .rst_n_i    (rst_n_i),
  .rst_sync_n (rst_sync_n),
  .left_i     (left_i),
  .right_i    (right_i),
  .count_o    (count_o),
  .state_o    (state_o)
);

// File: tb/seq_gate_counter_tb_top.sv
`timescale 1ns/1ps
module seq_gate_counter_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       left;
  logic       right;
  logic [2:0] count;
  logic [1:0] state;

  int n_vec  = 0;
  int n_fail = 0;
  int m_state;
  int m_cnt;
  logic [15:0] lfsr = 16'hACE1;

  always #2.5 clk = ~clk;

  seq_gate_counter dut_i (
    .clk_i   (clk),
    .rst_n_i (rst_n),
    .left_i  (left),
    .right_i (right),
    .count_o (count),
    .state_o (state)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference model built from the state table of R3 and the count rule of R2/R7/R8.
  task automatic model_step(input logic l, input logic r);
    int nxt;
    nxt = m_state;
    if (l && r) nxt = 0;
    else begin
      case (m_state)
        0: if (l) nxt = 1;
        1: if (!l) nxt = 2;
        2: if (r) nxt = 3; else if (l) nxt = 1;
        default: if (!r) begin nxt = 0; m_cnt = (m_cnt + 1) % 8; end
      endcase
    end
    m_state = nxt;
  endtask

  // Drive one cycle, then compare both outputs against the model.
  task automatic cyc(input logic l, input logic r, input string ts, input string tc);
    left  = l;
    right = r;
    @(posedge clk);
    model_step(l, r);
    @(negedge clk);
    check(ts, int'(state), m_state);
    check(tc, int'(count), m_cnt);
  endtask

  task automatic press(input bit is_left, input int hold, input int gap, input string tag);
    for (int i = 0; i < hold; i++) cyc(is_left, !is_left, tag, tag);
    for (int i = 0; i < gap; i++)  cyc(1'b0, 1'b0, tag, tag);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    #1;
    m_state = 0;
    m_cnt   = 0;
    check("R1", int'(state), 0);
    check("R1", int'(count), 0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) cyc(1'b0, 1'b0, "R1", "R1");
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    left  = 1'b0;
    right = 1'b0;
    m_state = 0;
    m_cnt   = 0;
    repeat (3) @(negedge clk);
    check("R1", int'(state), 0);
    check("R1", int'(count), 0);
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) cyc(1'b0, 1'b0, "R1", "R1");

    // R9: the scripted bounce-like series
    press(1'b1, 3, 4, "R9");
    press(1'b1, 3, 4, "R5");
    press(1'b0, 3, 4, "R2");
    press(1'b0, 3, 4, "R6");
    press(1'b1, 3, 4, "R9");
    press(1'b0, 3, 4, "R9");
    check("R9", int'(count), 2);

    // R4: right alone in idle does nothing
    press(1'b0, 4, 3, "R4");
    check("R4", int'(state), 0);
    check("R4", int'(count), 2);

    // R8: eight gestures wrap back to the starting value
    for (int g = 0; g < 8; g++) begin
      press(1'b1, 2, 2, "R8");
      press(1'b0, 2, 2, "R8");
    end
    check("R8", int'(count), 2);

    // R7: both buttons mid-gesture abandon it
    press(1'b1, 2, 2, "R7");
    cyc(1'b0, 1'b1, "R7", "R7");
    cyc(1'b1, 1'b1, "R7", "R7");
    check("R7", int'(state), 0);
    cyc(1'b0, 1'b0, "R7", "R7");
    check("R7", int'(count), 2);

    // R3: every state crossed with every input pair
    for (int s = 0; s < 4; s++) begin
      for (int in = 0; in < 4; in++) begin
        cyc(1'b1, 1'b1, "R7", "R7");
        cyc(1'b0, 1'b0, "R3", "R3");
        if (s >= 1) cyc(1'b1, 1'b0, "R3", "R3");
        if (s >= 2) cyc(1'b0, 1'b0, "R3", "R3");
        if (s >= 3) cyc(1'b0, 1'b1, "R3", "R3");
        check("R3", int'(state), s);
        cyc(in[1], in[0], "R3", "R2");
      end
    end

    // R1: asynchronous clear between edges
    press(1'b1, 2, 2, "R1");
    press(1'b0, 2, 2, "R1");
    @(posedge clk);
    #1;
    do_reset();

    // R3/R2: pseudo-random held levels compared cycle by cycle
    for (int k = 0; k < 3000; k++) begin
      int hold;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      hold = int'(lfsr[5:4]) + 1;
      for (int h = 0; h < hold; h++) cyc(lfsr[0], lfsr[1] & lfsr[2], "R3", "R2");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule